// File: doc/BRIEF.md
# Programmable parallel peripheral interface

This block sits on a CPU bus and drives three byte-wide parallel ports, A, B and C. It has one control register. A two-bit address selects port A, port B, port C or the control register. Reads and writes are single-cycle strobes on a synchronous clocked interface. Each pad is modelled as three signals: an input value, an output value and an output enable. A port configured as output drives its latched value until software writes it again. A port configured as input is read live from its pins.

A control write with bit 7 set is a mode word. It sets the directions of port A, port B and each half of port C, and it chooses between basic and strobed operation for port B. A control write with bit 7 clear leaves the modes alone and changes a single port C line.

In strobed operation, port B takes over the three low lines of port C. PC2 is a strobe or acknowledge input, PC1 is a buffer status output and PC0 is an interrupt request. The enable for this interrupt is the port C latch bit 2, which software changes with the single-bit word. Input transfers use a strobe that latches the pins. Output transfers use an acknowledge that frees the buffer.

Top module: `ppi_port`

## Requirements
- R1: A write with address 0, 1 or 2 loads the output latch of port A, B or C respectively, and leaves the other latches unchanged.
- R2: Latched output data appears on the port output from the cycle after the write and holds until the next write to that port.
- R3: A mode word (bit 7 = 1) sets the directions, with 1 = input and output enable low. Bit 4 sets port A, bit 3 sets PC7..PC4, bit 1 sets port B and bit 0 sets PC3..PC0. Bit 2 = 1 selects strobed operation for port B.
- R4: A mode word clears every output latch to 0 and clears the handshake buffer and interrupt state.
- R5: A control write with bit 7 = 0 writes bit 0 into the port C latch bit indexed by bits 3:1. The other port C bits and the mode are unchanged.
- R6: A read of port A or B in basic mode returns the live pins if the port is an input, and the latch if it is an output. A control read returns {1'b1, 2'b00, mode bits 4:0}.
- R7: A read of port C returns, for each bit, the pin if that line is an input and the driven output value if it is an output.
- R8: After reset every port is an input (all output enables 0), all latches are 0, and the control register reads 8'h9B.
- R9: In strobed operation, PC1 and PC0 are outputs and PC2 is an input, whatever the port B direction. PC3 still follows mode bit 0.
- R10: In strobed input, a falling PC2 latches the port B pins and raises PC1. A port B read returns the latched byte and clears PC1 and PC0.
- R11: A rising PC2 in strobed operation raises PC0 only if port C latch bit 2 is 1.
- R12: In strobed output, a port B write drives PC1 low and clears PC0. A falling PC2 drives PC1 high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wdata | input | W | Write data |
| rdata | output | W | Read data, 0 when no read is selected |
| pa_in | input | W | Port A pin values |
| pa_out | output | W | Port A driven values |
| pa_oe | output | W | Port A output enables |
| pb_in | input | W | Port B pin values |
| pb_out | output | W | Port B driven values |
| pb_oe | output | W | Port B output enables |
| pc_in | input | W | Port C pin values |
| pc_out | output | W | Port C driven values |
| pc_oe | output | W | Port C output enables |

## Verification
The bench builds the block with the default width W = 8. This is the only width for which the control and set/reset word layouts are defined. At this width all eight port C bit indices, both port C halves and every handshake line can be reached with single writes. A behavioural model in the bench runs beside the design. Mode words, single-bit writes, pin changes and strobe edges are then compared on every clock.

// File: rtl/ppi_port.sv
module ppi_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         rd,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  localparam int HW = W / 2;
  localparam logic [4:0] MODE_RST = 5'b11011;

  logic [4:0]   mode;
  logic [W-1:0] la, lb, lc, ib;
  logic         flag, intr, stb_q;

  wire wr_en   = sel & wr;
  wire rd_en   = sel & rd;
  wire wr_ctl  = wr_en && addr == 2'd3;
  wire mode_wr = wr_ctl && wdata[7];
  wire wr_b    = wr_en && addr == 2'd1;
  wire rd_b    = rd_en && addr == 2'd1;
  wire hs      = mode[2];
  wire b_in    = mode[1];
  wire stb_fall = stb_q & ~pc_in[2];
  wire stb_rise = ~stb_q & pc_in[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_RST;
      la <= '0;
      lb <= '0;
      lc <= '0;
    end else if (mode_wr) begin
      mode <= wdata[4:0];
      la <= '0;
      lb <= '0;
      lc <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: la <= wdata;
        2'd1: lb <= wdata;
        2'd2: lc <= wdata;
        default: lc[wdata[3:1]] <= wdata[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      intr  <= 1'b0;
      ib    <= '0;
      stb_q <= 1'b1;
    end else begin
      stb_q <= pc_in[2];
      if (mode_wr) begin
        flag <= 1'b0;
        intr <= 1'b0;
        ib   <= '0;
      end else if (hs) begin
        if (b_in) begin
          if (rd_b) begin
            flag <= 1'b0;
            intr <= 1'b0;
          end
          if (stb_fall) begin
            ib   <= pb_in;
            flag <= 1'b1;
          end
        end else begin
          if (stb_fall) flag <= 1'b0;
          if (wr_b) begin
            flag <= 1'b1;
            intr <= 1'b0;
          end
        end
        if (stb_rise && lc[2]) intr <= 1'b1;
      end
    end
  end

  assign pa_out = la;
  assign pa_oe  = {W{~mode[4]}};
  assign pb_out = lb;
  assign pb_oe  = {W{~b_in}};
  assign pc_out = hs ? {lc[W-1:3], lc[2], (b_in ? flag : ~flag), intr} : lc;
  assign pc_oe  = {{HW{~mode[3]}}, {(HW-3){~mode[0]}}, (hs ? 3'b011 : {3{~mode[0]}})};

  wire [W-1:0] pc_rd = (pc_oe & pc_out) | (~pc_oe & pc_in);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        2'd0: rdata = mode[4] ? pa_in : la;
        2'd1: rdata = (hs && b_in) ? ib : (b_in ? pb_in : lb);
        2'd2: rdata = pc_rd;
        default: rdata = {{(W-7){1'b1}}, 2'b00, mode};
      endcase
    end
  end
endmodule

// File: rtl/ppi_port_chk.sv
module ppi_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel,
  input logic         rd,
  input logic         wr,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] pa_out,
  input logic [W-1:0] pb_out,
  input logic [W-1:0] pc_in,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] pc_oe,
  input logic [4:0]   mode
);
  logic       bs_hit;
  logic [1:0] bs_idx;
  logic       bs_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bs_hit <= 1'b0;
      bs_idx <= 2'd0;
      bs_val <= 1'b0;
    end else begin
      bs_hit <= sel && wr && addr == 2'd3 && !wdata[7] && wdata[3];
      bs_idx <= wdata[2:1];
      bs_val <= wdata[0];
    end
  end

  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 2'd0) |=> pa_out == $past(wdata));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 2'd3 && wdata[7]) |=> (pa_out == '0 && pb_out == '0 && pc_out[W-1:4] == '0));

  assert_bitset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bs_hit |-> pc_out[4 + int'(bs_idx)] == bs_val);

  assert_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pc_oe[W-1:4]) == 0 || $countones(pc_oe[W-1:4]) == W/2));

  assert_intr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2] && $rose(pc_out[0])) |-> ($past(pc_in[2]) && !$past(pc_in[2], 2)));

  assert_obf_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2] && !mode[1] && sel && wr && addr == 2'd1) |=> !pc_out[1]);
endmodule

bind ppi_port ppi_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
  .wdata(wdata), .pa_out(pa_out), .pb_out(pb_out), .pc_in(pc_in),
  .pc_out(pc_out), .pc_oe(pc_oe), .mode(mode)
);

// File: tb/sim_ppi_port.sv
`timescale 1ns/100ps
module sim_ppi_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h04;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ppi_port u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [4:0] m_mode = 5'b11011;
  logic [7:0] m_a = 0, m_b = 0, m_c = 0, m_ib = 0;
  logic m_flag = 0, m_intr = 0, m_stb = 1;

  function automatic logic [7:0] e_pc_out();
    if (m_mode[2]) return {m_c[7:2], (m_mode[1] ? m_flag : ~m_flag), m_intr};
    return m_c;
  endfunction

  function automatic logic [7:0] e_pc_oe();
    logic [7:0] v;
    v[7:4] = m_mode[3] ? 4'h0 : 4'hF;
    v[3:0] = m_mode[0] ? 4'h0 : 4'hF;
    if (m_mode[2]) v[2:0] = 3'b011;
    return v;
  endfunction

  function automatic logic [7:0] e_rdata();
    logic [7:0] oe, po;
    if (!(sel && rd)) return 8'h00;
    oe = e_pc_oe();
    po = e_pc_out();
    case (addr)
      2'd0: return m_mode[4] ? pa_in : m_a;
      2'd1: begin
        if (m_mode[2] && m_mode[1]) return m_ib;
        return m_mode[1] ? pb_in : m_b;
      end
      2'd2: return (oe & po) | (~oe & pc_in);
      default: return {3'b100, m_mode};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 5'b11011; m_a = 0; m_b = 0; m_c = 0; m_ib = 0;
      m_flag = 0; m_intr = 0; m_stb = 1;
    end else begin
      bit fall, rise, en, mw;
      fall = m_stb && !pc_in[2];
      rise = !m_stb && pc_in[2];
      en = m_c[2];
      mw = sel && wr && addr == 3 && wdata[7];
      if (m_mode[2]) begin
        if (m_mode[1]) begin
          if (sel && rd && addr == 1) begin m_flag = 0; m_intr = 0; end
          if (fall) begin m_ib = pb_in; m_flag = 1; end
        end else begin
          if (fall) m_flag = 0;
          if (sel && wr && addr == 1) begin m_flag = 1; m_intr = 0; end
        end
        if (rise && en) m_intr = 1;
      end
      if (sel && wr) begin
        case (addr)
          2'd0: m_a = wdata;
          2'd1: m_b = wdata;
          2'd2: m_c = wdata;
          default: if (!wdata[7]) m_c[wdata[3:1]] = wdata[0];
        endcase
      end
      if (mw) begin
        m_mode = wdata[4:0]; m_a = 0; m_b = 0; m_c = 0;
        m_flag = 0; m_intr = 0; m_ib = 0;
      end
      m_stb = pc_in[2];
    end
    #1;
    chk("R2 pa_out model", pa_out, m_a);
    chk("R1 pb_out model", pb_out, m_b);
    chk("R3 pa_oe model", pa_oe, m_mode[4] ? 8'h00 : 8'hFF);
    chk("R3 pb_oe model", pb_oe, m_mode[1] ? 8'h00 : 8'hFF);
    chk("R9 pc_oe model", pc_oe, e_pc_oe());
    chk("R5 pc_out model", pc_out, e_pc_out());
    chk("R6 rdata model", rdata, e_rdata());
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sel = 1; rd = 1; addr = a;
    #1 chk(tag, rdata, exp);
    @(negedge clk);
    sel = 0; rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    #1;
    chk("R8 reset pa_oe", pa_oe, 8'h00);
    chk("R8 reset pb_oe", pb_oe, 8'h00);
    chk("R8 reset pc_oe", pc_oe, 8'h00);
    chk("R8 reset pc_out", pc_out, 8'h00);
    rd_reg(2'd3, 8'h9B, "R8 reset control read");
    pa_in = 8'h5A;
    rd_reg(2'd0, 8'h5A, "R6 live port A read");

    wr_reg(2'd3, 8'h80);
    #1;
    chk("R3 all out pa_oe", pa_oe, 8'hFF);
    chk("R3 all out pc_oe", pc_oe, 8'hFF);
    wr_reg(2'd0, 8'h3C);
    wr_reg(2'd1, 8'hC3);
    wr_reg(2'd2, 8'h69);
    #1;
    chk("R1 port A latch", pa_out, 8'h3C);
    chk("R1 port B latch", pb_out, 8'hC3);
    chk("R1 port C latch", pc_out, 8'h69);
    pa_in = 8'hFF;
    idle(4);
    #1 chk("R2 port A held", pa_out, 8'h3C);
    rd_reg(2'd0, 8'h3C, "R6 output port reads latch");

    wr_reg(2'd3, 8'h0F);
    #1 chk("R5 set bit 7", pc_out, 8'hE9);
    wr_reg(2'd3, 8'h06);
    #1 chk("R5 reset bit 3", pc_out, 8'hE1);
    rd_reg(2'd3, 8'h80, "R5 mode unchanged");

    wr_reg(2'd3, 8'h88);
    #1;
    chk("R3 upper C input", pc_oe, 8'h0F);
    chk("R4 latch A cleared", pa_out, 8'h00);
    chk("R4 latch C cleared", pc_out, 8'h00);
    pc_in = 8'hA5;
    wr_reg(2'd2, 8'h03);
    rd_reg(2'd2, 8'hA3, "R7 mixed port C read");
    wr_reg(2'd3, 8'h81);
    #1 chk("R3 lower C input", pc_oe, 8'hF0);

    pc_in = 8'h04;
    wr_reg(2'd3, 8'h86);
    #1;
    chk("R9 strobed input pc_oe", pc_oe, 8'hFB);
    chk("R9 strobed input pb_oe", pb_oe, 8'h00);
    wr_reg(2'd3, 8'h05);
    pb_in = 8'h77;
    @(negedge clk) pc_in = 8'h00;
    idle(1);
    #1 chk("R10 buffer full", pc_out & 8'h03, 8'h02);
    pb_in = 8'h11;
    @(negedge clk) pc_in = 8'h04;
    idle(1);
    #1 chk("R11 interrupt raised", pc_out & 8'h03, 8'h03);
    rd_reg(2'd1, 8'h77, "R10 latched port B read");
    #1 chk("R10 read clears flags", pc_out & 8'h03, 8'h00);
    wr_reg(2'd3, 8'h04);
    @(negedge clk) pc_in = 8'h00;
    idle(1);
    @(negedge clk) pc_in = 8'h04;
    idle(2);
    #1 chk("R11 no interrupt when disabled", pc_out & 8'h03, 8'h02);

    wr_reg(2'd3, 8'h84);
    #1;
    chk("R12 strobed output pb_oe", pb_oe, 8'hFF);
    chk("R12 buffer empty after mode", pc_out & 8'h03, 8'h02);
    wr_reg(2'd3, 8'h05);
    wr_reg(2'd1, 8'h42);
    #1;
    chk("R12 port B driven", pb_out, 8'h42);
    chk("R12 buffer full low", pc_out & 8'h03, 8'h00);
    @(negedge clk) pc_in = 8'h00;
    idle(1);
    #1 chk("R12 ack frees buffer", pc_out & 8'h03, 8'h02);
    @(negedge clk) pc_in = 8'h04;
    idle(1);
    #1 chk("R11 output interrupt", pc_out & 8'h03, 8'h03);
    wr_reg(2'd1, 8'h24);
    #1 chk("R12 write clears interrupt", pc_out & 8'h03, 8'h00);

    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule